// File: doc/BRIEF.md
# Indexed Colour Palette with Byte-Serial Host Port

This block is a colour lookup table for a display pipeline. It has 256 entries, and each entry holds an 8-bit red, an 8-bit green and an 8-bit blue component. The scan-out side presents an 8-bit pixel index every cycle. One cycle later the block returns the stored 24-bit colour.

A host loads the table through a narrow byte bus with a small address space. It first selects an entry through the index register. It then pushes three bytes through the data register, red first, then green, then blue. An internal phase counter tracks which component comes next. The entry is committed as a whole when the blue byte arrives, and the index then steps to the next entry, so a whole table can be streamed after a single index write.

A mode-control register holds a screen-off bit. While that bit is set, the colour output is forced to black, but the table can still be loaded.

Top module: `clut_port`

## Requirements
- R1: After reset, entry i holds the value i in each of its red, green and blue components, for every i. The pixel output is zero, the index register is 0 and the mode-control register is 0.
- R2: The host address map is 0 = index register, 1 = data register, 2 = mode-control register, 3 = unused. A write to address 0 loads the entry index and returns the component phase to red.
- R3: Data-register writes fill red, green and blue in that order. The 24-bit entry {red[23:16], green[15:8], blue[7:0]} changes only when the blue byte is written. An update that stops after red or green leaves the entry unchanged.
- R4: When the blue byte is written, the index advances by one, wrapping from 255 to 0, and the phase returns to red.
- R5: The pixel output is registered with a latency of one cycle. A lookup sampled on the same clock edge as the blue write returns the old colour, and the lookup on the next edge returns the new colour.
- R6: Bit 5 of the mode-control register is screen-off. From the first lookup after it is set, the pixel output is all zeros. The other bits of that register have no effect on the pixel output.
- R7: Palette writes made while screen-off is set are stored, and they appear once screen-off is cleared.
- R8: Host reads are combinational. Address 0 returns the current index, address 2 returns the mode-control register, and addresses 1 and 3 return zero.
- R9: Writes to address 3 change neither the index, the mode-control register nor any palette entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Host write strobe for one cycle |
| hostAddr | input | 2 | Host register address |
| hostWrData | input | 8 | Host write byte |
| hostRdData | output | 8 | Host read byte, combinational from hostAddr |
| pixIdx | input | 8 | Pixel palette index |
| pixRgb | output | 24 | Looked-up colour {red, green, blue}, one cycle after pixIdx |

## Verification
A host write takes effect on the clock edge that samples it. The pixel output for an index shows up on the edge after the index is sampled. Host reads are combinational and therefore valid as soon as the address settles.

The bench drives every input on the falling edge and samples every output on the next falling edge, so each lookup is compared exactly one edge after its index was captured. The latency case drives the blue write and the lookup index in the same half cycle. It expects the old colour at the first falling edge and the new colour at the second. Screen-off is checked on the lookup that follows the control write.

// File: rtl/clut_pkg.sv
package clut_pkg;

  typedef enum logic [1:0] {
    PH_RED   = 2'd0,
    PH_GREEN = 2'd1,
    PH_BLUE  = 2'd2
  } phase_t;

  typedef enum logic [1:0] {
    HA_INDEX = 2'd0,
    HA_DATA  = 2'd1,
    HA_CTRL  = 2'd2,
    HA_NONE  = 2'd3
  } hostAddr_t;

  // Control-to-datapath strobes.
  typedef struct packed {
    logic   commit;   // write the staged colour into the selected entry
    logic   blank;    // screen-off
    phase_t phase;    // next component expected on the data register
  } clutStrobes_t;

endpackage

// File: rtl/clut_ctrl.sv
module clut_ctrl
  import clut_pkg::*;
#(
  parameter int IDX_W     = 8,
  parameter int COMP_W    = 8,
  parameter int BLANK_BIT = 5,
  localparam int RGB_W    = 3 * COMP_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                hostWrEn,
  input  logic [1:0]          hostAddr,
  input  logic [COMP_W-1:0]   hostWrData,
  output logic [COMP_W-1:0]   hostRdData,
  output clutStrobes_t        strb,
  output logic [IDX_W-1:0]    entryIdx,
  output logic [RGB_W-1:0]    entryRgb
);

  logic [IDX_W-1:0]  indexQ;
  logic [COMP_W-1:0] redQ, greenQ;
  logic [COMP_W-1:0] ctrlQ;
  phase_t            phaseQ;

  logic wrIndex, wrData, wrCtrl;

  always_comb begin
    wrIndex = hostWrEn && (hostAddr == HA_INDEX);
    wrData  = hostWrEn && (hostAddr == HA_DATA);
    wrCtrl  = hostWrEn && (hostAddr == HA_CTRL);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      indexQ <= '0;
      phaseQ <= PH_RED;
      redQ   <= '0;
      greenQ <= '0;
      ctrlQ  <= '0;
    end else begin
      if (wrIndex) begin
        indexQ <= hostWrData[IDX_W-1:0];
        phaseQ <= PH_RED;
      end else if (wrData) begin
        unique case (phaseQ)
          PH_RED: begin
            redQ   <= hostWrData;
            phaseQ <= PH_GREEN;
          end
          PH_GREEN: begin
            greenQ <= hostWrData;
            phaseQ <= PH_BLUE;
          end
          PH_BLUE: begin
            indexQ <= indexQ + 1'b1;
            phaseQ <= PH_RED;
          end
          default: phaseQ <= PH_RED;
        endcase
      end
      if (wrCtrl) ctrlQ <= hostWrData;
    end
  end

  always_comb begin
    strb.commit = wrData && (phaseQ == PH_BLUE);
    strb.blank  = ctrlQ[BLANK_BIT];
    strb.phase  = phaseQ;
    entryIdx    = indexQ;
    entryRgb    = {redQ, greenQ, hostWrData};
  end

  always_comb begin
    hostRdData = '0;
    unique case (hostAddr)
      HA_INDEX: hostRdData[IDX_W-1:0] = indexQ;
      HA_CTRL:  hostRdData = ctrlQ;
      default:  hostRdData = '0;
    endcase
  end

endmodule

// File: rtl/clut_store.sv
module clut_store
  import clut_pkg::*;
#(
  parameter int IDX_W   = 8,
  parameter int COMP_W  = 8,
  localparam int ENTRIES = 1 << IDX_W,
  localparam int RGB_W   = 3 * COMP_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  clutStrobes_t       strb,
  input  logic [IDX_W-1:0]   entryIdx,
  input  logic [RGB_W-1:0]   entryRgb,
  input  logic [IDX_W-1:0]   pixIdx,
  output logic [RGB_W-1:0]   pixRgb
);

  logic [RGB_W-1:0] tableQ [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : gEntry
    localparam logic [COMP_W-1:0] IDENT = COMP_W'(g);
    always_ff @(posedge clk) begin
      if (!rstN)
        tableQ[g] <= {IDENT, IDENT, IDENT};
      else if (strb.commit && (entryIdx == IDX_W'(g)))
        tableQ[g] <= entryRgb;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)          pixRgb <= '0;
    else if (strb.blank) pixRgb <= '0;
    else                pixRgb <= tableQ[pixIdx];
  end

endmodule

// File: rtl/clut_port.sv
module clut_port
  import clut_pkg::*;
#(
  parameter int IDX_W     = 8,
  parameter int COMP_W    = 8,
  parameter int BLANK_BIT = 5,
  localparam int RGB_W    = 3 * COMP_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic [1:0]        hostAddr,
  input  logic [COMP_W-1:0] hostWrData,
  output logic [COMP_W-1:0] hostRdData,
  input  logic [IDX_W-1:0]  pixIdx,
  output logic [RGB_W-1:0]  pixRgb
);

  clutStrobes_t     strb;
  logic [IDX_W-1:0] entryIdx;
  logic [RGB_W-1:0] entryRgb;

  clut_ctrl #(.IDX_W(IDX_W), .COMP_W(COMP_W), .BLANK_BIT(BLANK_BIT)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .hostWrEn(hostWrEn), .hostAddr(hostAddr), .hostWrData(hostWrData),
    .hostRdData(hostRdData),
    .strb(strb), .entryIdx(entryIdx), .entryRgb(entryRgb)
  );

  clut_store #(.IDX_W(IDX_W), .COMP_W(COMP_W)) store_i (
    .clk(clk), .rstN(rstN),
    .strb(strb), .entryIdx(entryIdx), .entryRgb(entryRgb),
    .pixIdx(pixIdx), .pixRgb(pixRgb)
  );

endmodule

// File: rtl/clut_port_chk.sv
module clut_port_chk
  import clut_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 8,
  localparam int RGB_W = 3 * COMP_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              hostWrEn,
  input logic [1:0]        hostAddr,
  input logic [COMP_W-1:0] hostWrData,
  input logic [RGB_W-1:0]  pixRgb,
  input clutStrobes_t      strb,
  input logic [IDX_W-1:0]  entryIdx
);

  assert_index_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && hostAddr == 2'd0) |=>
      (strb.phase == PH_RED && entryIdx == $past(hostWrData[IDX_W-1:0])));

  assert_red_to_green_R3: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && hostAddr == 2'd1 && strb.phase == PH_RED) |=> strb.phase == PH_GREEN);

  assert_green_to_blue_R3: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && hostAddr == 2'd1 && strb.phase == PH_GREEN) |=> strb.phase == PH_BLUE);

  assert_advance_wrap_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> (strb.phase == PH_RED && entryIdx == IDX_W'($past(entryIdx) + 1'b1)));

  assert_blank_black_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.blank |=> pixRgb == '0);

  assert_unused_addr_R9: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && hostAddr == 2'd3) |=> ($stable(entryIdx) && $stable(strb.blank)));

endmodule

bind clut_port clut_port_chk #(.IDX_W(IDX_W), .COMP_W(COMP_W)) chk_i (
  .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
  .hostWrData(hostWrData), .pixRgb(pixRgb), .strb(strb), .entryIdx(entryIdx)
);

// File: tb/clut_port_tb_top.sv
module clut_port_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        hostWrEn;
  logic [1:0]  hostAddr;
  logic [7:0]  hostWrData;
  logic [7:0]  hostRdData;
  logic [7:0]  pixIdx;
  logic [23:0] pixRgb;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clut_port dut_i (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostRdData(hostRdData),
    .pixIdx(pixIdx), .pixRgb(pixRgb)
  );

  function automatic logic [7:0] pat(int i, int c);
    return 8'((i * 37 + c * 101 + 5) & 255);
  endfunction

  function automatic logic [23:0] patRgb(int i);
    return {pat(i, 0), pat(i, 1), pat(i, 2)};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge.
  task automatic hostWr(logic [1:0] a, logic [7:0] d);
    hostWrEn = 1'b1; hostAddr = a; hostWrData = d;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic hostRd(logic [1:0] a, output logic [7:0] d);
    hostAddr = a;
    #1;
    d = hostRdData;
  endtask

  task automatic lookup(logic [7:0] i);
    pixIdx = i;
    @(negedge clk);
  endtask

  task automatic writeEntry(logic [7:0] i, logic [23:0] rgb);
    hostWr(2'd0, i);
    hostWr(2'd1, rgb[23:16]);
    hostWr(2'd1, rgb[15:8]);
    hostWr(2'd1, rgb[7:0]);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    logic [7:0] rd;
    rstN = 1'b0; hostWrEn = 1'b0; hostAddr = 2'd0; hostWrData = '0; pixIdx = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    check("R1 pixRgb", 32'(pixRgb), 32'h0);
    hostRd(2'd0, rd); check("R1 index", 32'(rd), 32'h0);
    hostRd(2'd2, rd); check("R1 ctrl", 32'(rd), 32'h0);
    for (int i = 0; i < 256; i++) begin
      lookup(8'(i));
      check("R1 identity", 32'(pixRgb), 32'({8'(i), 8'(i), 8'(i)}));
    end

    // R2/R3/R4: stream the whole table after one index write
    hostWr(2'd0, 8'd0);
    for (int i = 0; i < 256; i++)
      for (int c = 0; c < 3; c++)
        hostWr(2'd1, pat(i, c));
    hostRd(2'd0, rd); check("R4 index wrapped after full load", 32'(rd), 32'h0);
    for (int i = 0; i < 256; i++) begin
      lookup(8'(i));
      check("R3 streamed entry", 32'(pixRgb), 32'(patRgb(i)));
    end

    // R4: explicit wrap from 255 to 0
    writeEntry(8'd255, 24'hA1A2A3);
    hostRd(2'd0, rd); check("R4 index after 255", 32'(rd), 32'h0);
    hostWr(2'd1, 8'hB1); hostWr(2'd1, 8'hB2); hostWr(2'd1, 8'hB3);
    hostRd(2'd0, rd); check("R4 index after entry 0", 32'(rd), 32'h1);
    lookup(8'd255); check("R4 entry 255", 32'(pixRgb), 32'h00A1A2A3);
    lookup(8'd0);   check("R4 entry 0 via wrap", 32'(pixRgb), 32'h00B1B2B3);

    // R2/R3: partial update abandoned by an index write
    hostWr(2'd0, 8'd10); hostWr(2'd1, 8'h11); hostWr(2'd1, 8'h22);
    lookup(8'd10); check("R3 partial leaves entry", 32'(pixRgb), 32'(patRgb(10)));
    writeEntry(8'd20, 24'h334455);
    lookup(8'd20); check("R2 phase reset by index write", 32'(pixRgb), 32'h00334455);
    lookup(8'd10); check("R2 abandoned entry unchanged", 32'(pixRgb), 32'(patRgb(10)));
    hostRd(2'd0, rd); check("R8 index read", 32'(rd), 32'd21);

    // R5: latency, write and lookup on the same edge
    hostWr(2'd0, 8'd30); hostWr(2'd1, 8'h77); hostWr(2'd1, 8'h88);
    pixIdx = 8'd30;
    hostWr(2'd1, 8'h99);
    check("R5 same-edge lookup old", 32'(pixRgb), 32'(patRgb(30)));
    @(negedge clk);
    check("R5 next lookup new", 32'(pixRgb), 32'h00778899);

    // R6: other control bits have no effect; bit 5 blanks
    hostWr(2'd2, 8'hDF);
    lookup(8'd40); check("R6 non-blank bits", 32'(pixRgb), 32'(patRgb(40)));
    hostRd(2'd2, rd); check("R8 ctrl read", 32'(rd), 32'hDF);
    hostWr(2'd2, 8'h20);
    for (int i = 40; i < 44; i++) begin
      lookup(8'(i)); check("R6 blanked", 32'(pixRgb), 32'h0);
    end

    // R7: writes accepted while blanked
    writeEntry(8'd50, 24'hC0FFEE);
    lookup(8'd50); check("R7 still black", 32'(pixRgb), 32'h0);
    hostWr(2'd2, 8'h00);
    lookup(8'd50); check("R7 stored while blanked", 32'(pixRgb), 32'h00C0FFEE);

    // R8/R9: unused address
    hostRd(2'd1, rd); check("R8 data read zero", 32'(rd), 32'h0);
    hostRd(2'd3, rd); check("R8 unused read zero", 32'(rd), 32'h0);
    hostWr(2'd3, 8'hAB);
    hostRd(2'd0, rd); check("R9 index kept", 32'(rd), 32'd51);
    hostRd(2'd2, rd); check("R9 ctrl kept", 32'(rd), 32'h0);
    lookup(8'd51); check("R9 entry kept", 32'(pixRgb), 32'(patRgb(51)));
    hostWr(2'd1, 8'h01); hostWr(2'd1, 8'h02); hostWr(2'd1, 8'h03);
    lookup(8'd51); check("R9 phase kept", 32'(pixRgb), 32'h00010203);

    finish();
  end

endmodule